// File: doc/BRIEF.md
# Pulse Interval Capture Timer

This block measures the spacing between the leading edges of an external pulse train. An up-counter advances by one on every clock cycle in which the tick enable is high. The capture pin is asynchronous to the block clock. It first passes through a synchronizer chain and then through a rising-edge detector. The detector produces a single-cycle capture strobe for each leading edge of the input.

On each strobe the counter value is copied into a capture register and an interrupt request is raised. A mode input selects what happens to the counter on a capture:

- In restart mode the counter returns to zero, so the captured value is directly the interval since the previous edge.
- In free-run mode the counter keeps running, and software works out the interval by subtracting successive captures.

Three flags report to the processor:

- The interrupt request, which the processor clears.
- An overrun flag, set when a capture arrives while the request is still pending.
- An overflow flag, set when the counter wraps.

Top module: `pulse_capture_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `count`, `cap_value`, `irq`, `overrun` and `overflow` are all zero.
- R2: With no capture strobe, `count` rises by one on each clock edge at which `tick_en` is high and holds its value when `tick_en` is low.
- R3: A rising edge on `cap_pin` takes effect at the third rising clock edge after it is sampled high. At that edge `cap_value` takes the value that `count` held just before the edge, and `irq` goes to 1. With the default two-stage synchronizer, `irq` is still 0 after the second edge.
- R4: With `mode_free` = 0 (restart mode), the capture edge sets `count` to 0 even when `tick_en` is high. Two leading edges D cycles apart, with `tick_en` held high, therefore capture D-1.
- R5: With `mode_free` = 1 (free-run mode), a capture does not disturb the counter, which continues counting as in R2.
- R6: Only a 0-to-1 transition of the synchronized pin captures. A pin held high, or a falling edge, produces no further capture, and `irq` stays cleared.
- R7: A high `irq_clr` at a clock edge clears both `irq` and `overrun`. If a capture strobe occurs at the same edge, the capture wins and `irq` stays 1.
- R8: A capture that occurs while `irq` is 1 sets `overrun` to 1 and still overwrites `cap_value` with the newer count.
- R9: When the counter advances from all-ones (8'hFF by default) it wraps to 0 and sets `overflow`. A high `ovf_clr` clears `overflow`, but a wrap at the same edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable for the current cycle |
| cap_pin | input | 1 | Asynchronous capture input |
| mode_free | input | 1 | 0 = restart counter on capture, 1 = free-run |
| irq_clr | input | 1 | Clears `irq` and `overrun` |
| ovf_clr | input | 1 | Clears `overflow` |
| count | output | CNT_W (8) | Present counter value |
| cap_value | output | CNT_W (8) | Last captured count |
| irq | output | 1 | Capture interrupt request |
| overrun | output | 1 | Capture occurred while request pending |
| overflow | output | 1 | Counter wrapped since last clear |

## Verification
A fault in the edge-detector history or the synchronizer chain has two possible symptoms at the ports, and both appear within three cycles of a pin transition:

- A missed capture.
- A second capture on a held-high or falling pin, which re-raises `irq` after it was cleared.

A counter fault shows up in `count` at the next enabled edge. It also appears later in `cap_value`, where a wrong captured interval points back to the clear-versus-continue choice on the capture edge.

Flag priority faults are only visible at coincident edges, when a clear and a set land on the same cycle. For that reason the coincidences are driven deliberately and the flag is read one cycle later.

// File: rtl/capt_pkg.sv
package capt_pkg;

    // Counter behaviour on a capture event
    typedef enum logic {
        MODE_RESTART = 1'b0,
        MODE_FREERUN = 1'b1
    } cap_mode_e;

    // Processor-visible status flags
    typedef struct packed {
        logic irq;
        logic overrun;
        logic overflow;
    } cap_flags_t;

    localparam cap_flags_t FLAGS_IDLE = '{irq: 1'b0, overrun: 1'b0, overflow: 1'b0};

    // Next state of a set/clear flag: set has priority over clear
    function automatic logic set_wins(input logic cur, input logic set, input logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

endpackage

// File: rtl/capt_edge_sync.sv
module capt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic stb
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[LAST-1:0], pin};
            prev  <= chain[LAST];
        end
    end

    assign stb = chain[LAST] & ~prev;
endmodule

// File: rtl/capt_counter.sv
module capt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign wrap = tick && !restart && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (restart) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/capt_status.sv
module capt_status
    import capt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    input  logic             irq_clr,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cap_q,
    output cap_flags_t       flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            flags <= FLAGS_IDLE;
        end else begin
            if (stb) cap_q <= cnt;
            flags.irq      <= set_wins(flags.irq, stb, irq_clr);
            flags.overrun  <= set_wins(flags.overrun, stb && flags.irq, irq_clr);
            flags.overflow <= set_wins(flags.overflow, wrap, ovf_clr);
        end
    end
endmodule

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer
    import capt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             cap_pin,
    input  logic             mode_free,
    input  logic             irq_clr,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_value,
    output logic             irq,
    output logic             overrun,
    output logic             overflow
);
    cap_mode_e  mode;
    cap_flags_t flags;
    logic       cap_stb;
    logic       restart;
    logic       wrap;

    assign mode    = cap_mode_e'(mode_free);
    assign restart = cap_stb && (mode == MODE_RESTART);

    capt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (cap_pin),
        .stb (cap_stb)
    );

    capt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .restart (restart),
        .cnt     (count),
        .wrap    (wrap)
    );

    capt_status #(.CNT_W(CNT_W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .stb     (cap_stb),
        .cnt     (count),
        .wrap    (wrap),
        .irq_clr (irq_clr),
        .ovf_clr (ovf_clr),
        .cap_q   (cap_value),
        .flags   (flags)
    );

    assign irq      = flags.irq;
    assign overrun  = flags.overrun;
    assign overflow = flags.overflow;
endmodule

// File: rtl/capt_timer_chk.sv
module capt_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             mode_free,
    input logic             irq_clr,
    input logic             cap_stb,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cap_value,
    input logic             irq,
    input logic             overrun,
    input logic             overflow
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cap_stb) |=> count == CNT_W'($past(count) + 1'b1));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cap_stb) |=> $stable(count));

    assert_capture_load_R3: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> (irq && cap_value == $past(count)));

    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && !mode_free) |=> count == '0);

    assert_free_continue_R5: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && mode_free && tick_en) |=> count == CNT_W'($past(count) + 1'b1));

    assert_no_spurious_capture_R6: assert property (@(posedge clk) disable iff (rst)
        !cap_stb |=> $stable(cap_value));

    assert_irq_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !cap_stb) |=> (!irq && !overrun));

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && irq) |=> overrun);

    assert_wrap_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (tick_en && count == MAXV && !(cap_stb && !mode_free)) |=> (overflow && count == '0));
endmodule

bind pulse_capture_timer capt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .mode_free (mode_free),
    .irq_clr   (irq_clr),
    .cap_stb   (cap_stb),
    .count     (count),
    .cap_value (cap_value),
    .irq       (irq),
    .overrun   (overrun),
    .overflow  (overflow)
);

// File: tb/pulse_capture_timer_tb.sv
module pulse_capture_timer_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en, cap_pin, mode_free, irq_clr, ovf_clr;
    logic [7:0] count, cap_value;
    logic       irq, overrun, overflow;
    int         n_run  = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    pulse_capture_timer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cap_pin(cap_pin),
        .mode_free(mode_free), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
        .count(count), .cap_value(cap_value), .irq(irq),
        .overrun(overrun), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic free);
        @(negedge clk);
        rst = 1'b1; tick_en = 1'b0; cap_pin = 1'b0;
        mode_free = free; irq_clr = 1'b0; ovf_clr = 1'b0;
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Raise pin now; return at the negedge right after the capture edge
    task automatic pulse_pin();
        cap_pin = 1'b1;
        wait_n(2);
        cap_pin = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 count",    count, 0);
        chk("R1 cap",      cap_value, 0);
        chk("R1 irq",      irq, 0);
        chk("R1 overrun",  overrun, 0);
        chk("R1 overflow", overflow, 0);
    endtask

    task automatic t_count();
        do_reset(1'b0);
        tick_en = 1'b1; wait_n(10);
        chk("R2 count after 10 ticks", count, 10);
        tick_en = 1'b0; wait_n(5);
        chk("R2 count held", count, 10);
    endtask

    task automatic t_capture_restart();
        do_reset(1'b0);
        tick_en = 1'b1; wait_n(20);
        tick_en = 1'b0;
        cap_pin = 1'b1;
        wait_n(2);
        chk("R3 irq not yet", irq, 0);
        cap_pin = 1'b0;
        @(negedge clk);
        chk("R3 irq raised", irq, 1);
        chk("R3 captured",   cap_value, 20);
        chk("R4 cleared",    count, 0);
    endtask

    task automatic t_interval();
        do_reset(1'b0);
        tick_en = 1'b1;
        pulse_pin();
        wait_n(34);
        pulse_pin();
        chk("R4 interval D-1", cap_value, 36);
        chk("R4 cleared with tick high", count, 0);
    endtask

    task automatic t_free();
        do_reset(1'b1);
        tick_en = 1'b1; wait_n(50);
        pulse_pin();
        chk("R5 captured", cap_value, 52);
        chk("R5 not cleared", count, 53);
    endtask

    task automatic t_level();
        do_reset(1'b0);
        cap_pin = 1'b1; wait_n(3);
        chk("R6 first edge", irq, 1);
        clear_irq();
        wait_n(5);
        chk("R6 held high", irq, 0);
        cap_pin = 1'b0; wait_n(5);
        chk("R6 falling edge", irq, 0);
    endtask

    task automatic t_overrun();
        do_reset(1'b0);
        pulse_pin();
        chk("R8 first cap", cap_value, 0);
        chk("R8 no overrun yet", overrun, 0);
        tick_en = 1'b1; wait_n(5);
        tick_en = 1'b0;
        pulse_pin();
        chk("R8 overwritten", cap_value, 5);
        chk("R8 overrun", overrun, 1);
        clear_irq();
        chk("R7 irq cleared", irq, 0);
        chk("R7 overrun cleared", overrun, 0);
    endtask

    task automatic t_clear_race();
        do_reset(1'b0);
        pulse_pin();
        wait_n(2);
        cap_pin = 1'b1;
        wait_n(2);
        cap_pin = 1'b0; irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R7 capture beats clear", irq, 1);
        chk("R7 overrun on race", overrun, 1);
    endtask

    task automatic t_wrap();
        do_reset(1'b0);
        tick_en = 1'b1; wait_n(255);
        chk("R9 at max", count, 255);
        chk("R9 no overflow yet", overflow, 0);
        @(negedge clk);
        chk("R9 wrapped", count, 0);
        chk("R9 overflow set", overflow, 1);
        tick_en = 1'b0; ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R9 overflow cleared", overflow, 0);
        tick_en = 1'b1; wait_n(255);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R9 wrap beats clear", overflow, 1);
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_capture_restart();
        t_interval();
        t_free();
        t_level();
        t_overrun();
        t_clear_race();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule